// File: doc/BRIEF.md
# Fixed-Vector Interrupt Request Resolver

This block sits beside a small 8-bit processor core. It takes four interrupt request lines and turns them into a single service decision. Three of the lines are direct requests, and each one has a fixed 16-bit branch address. The fourth line is externally vectored: when it is chosen, the block drives an active-low acknowledge so that the requesting peripheral can place its own vector on the bus. The core pulses `boundary_i` when an instruction completes, and a request can only be taken on that strobe.

The highest-priority line is edge-triggered. A rising edge sets a sticky pending flag. The flag stays set until the request is taken or firmware clears it. The other three lines are level-sensitive and are sampled only at the boundary strobe. When a request is taken, the block raises `take_o` for one cycle and presents the vector and the kind of request. It also clears the global enable, so firmware must set the enable again before the next request can be taken. Priority is only compared among requests that are pending at that moment. A request that has already been taken does not compete, so a lower line can interrupt the service of a higher one once the enable is set again.

Top module: `irq_vector_resolver`

## Requirements
- R1: While reset is held and just after it is released, `take_o` is 0, `ack_n_o` is 1 and `ien_o` is 0.
- R2: A request is taken only when `boundary_i` is 1 and `ien_o` is 1 in the same cycle. The `take_o` pulse appears in the next cycle and lasts exactly one cycle.
- R3: When several requests are eligible together, the winner is chosen in this order: edge line (highest), then middle level line, then low level line, then the externally vectored line (lowest).
- R4: A taken direct request gives `vector_o` = 16'h003C for the edge line, 16'h0034 for the middle line and 16'h002C for the low line. In each case `ext_o` is 0 and `ack_n_o` stays 1.
- R5: A taken external request gives `ext_o` = 1 and `vector_o` = 16'h0000, and drives `ack_n_o` low only in the cycle of `take_o`.
- R6: Taking any request clears `ien_o` in the cycle of `take_o`. No further take happens until `ien_set_i` is pulsed.
- R7: The edge line records a 0-to-1 transition as pending, and the pending state survives after the line drops. If the line is held high after its request is taken, it does not request again.
- R8: A level line that falls before the boundary strobe leaves no request behind.
- R9: `mask_i` bit 2 blocks the edge line, bit 1 blocks the middle line and bit 0 blocks the low line. Masking does not clear a latched edge request, which is taken once it is unmasked. The external line has no mask bit.
- R10: A pulse on `pend_clr_i` discards a latched edge request.
- R11: Taking the edge request clears its pending state. Lower requests that remain are taken on later boundaries once the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction-complete strobe from the core |
| req_edge_i | input | 1 | Highest-priority direct request, rising-edge triggered |
| req_mid_i | input | 1 | Middle direct request, level |
| req_low_i | input | 1 | Lowest direct request, level |
| req_ext_i | input | 1 | Externally vectored request, level |
| mask_i | input | 3 | Direct masks: bit2 edge, bit1 mid, bit0 low |
| ien_set_i | input | 1 | Firmware pulse that sets the global enable |
| pend_clr_i | input | 1 | Firmware pulse that discards the latched edge request |
| take_o | output | 1 | One-cycle pulse when a request is taken |
| vector_o | output | 16 | Branch address of the last taken request |
| ext_o | output | 1 | 1 when the last taken request was the external one |
| ack_n_o | output | 1 | Active-low acknowledge for the external request |
| ien_o | output | 1 | Global interrupt enable state |

## Verification
The bench builds the block with its default parameters: a 16-bit address and the three fixed vectors 003C, 0034 and 002C. With these values, every expected address in the bench can be written down literally. A behavioural model that runs in parallel is compared against the outputs on every clock. Directed sequences then cover the cases the model alone would not reach:
- four simultaneous requests drained one at a time;
- a masked edge request that survives until it is unmasked;
- a level line that drops before the strobe;
- an edge line held high across its own service.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int DIRECT_N = 3;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_HI   = 3'd1,
    SRC_MID  = 3'd2,
    SRC_LO   = 3'd3,
    SRC_EXT  = 3'd4
  } irq_src_e;

  // Fixed priority over the eligible lines: live[2] highest, ext lowest.
  function automatic irq_src_e pick_src(input logic [DIRECT_N-1:0] live, input logic ext);
    if (live[2])      return SRC_HI;
    else if (live[1]) return SRC_MID;
    else if (live[0]) return SRC_LO;
    else if (ext)     return SRC_EXT;
    else              return SRC_NONE;
  endfunction
endpackage

// File: rtl/irqv_edge_pend.sv
module irqv_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic rise,
  output logic pend
);
  logic req_q;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      req_q <= req;
      // a new edge wins over a clear in the same cycle
      if (rise)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic [DIRECT_N-1:0] direct_req,
  input  logic [DIRECT_N-1:0] mask,
  input  logic                ext_req,
  output logic [DIRECT_N-1:0] direct_live,
  output irq_src_e            sel_src
);
  for (genvar g = 0; g < DIRECT_N; g++) begin : g_gate
    assign direct_live[g] = direct_req[g] & ~mask[g];
  end

  assign sel_src = pick_src(direct_live, ext_req);
endmodule

// File: rtl/irqv_issue.sv
module irqv_issue
  import irqv_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_HI  = 'h3C,
  parameter logic [ADDR_W-1:0] VEC_MID = 'h34,
  parameter logic [ADDR_W-1:0] VEC_LO  = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  irq_src_e          sel_src,
  input  logic              ien_set,
  output logic              take,
  output logic [ADDR_W-1:0] vector,
  output logic              ext,
  output logic              ack_n,
  output logic              ien
);
  function automatic logic [ADDR_W-1:0] vec_of(input irq_src_e s);
    case (s)
      SRC_HI:  return VEC_HI;
      SRC_MID: return VEC_MID;
      SRC_LO:  return VEC_LO;
      default: return '0;
    endcase
  endfunction

  logic sel_ext;
  assign sel_ext = (sel_src == SRC_EXT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take   <= 1'b0;
      vector <= '0;
      ext    <= 1'b0;
      ack_n  <= 1'b1;
      ien    <= 1'b0;
    end else begin
      take  <= fire;
      ack_n <= ~(fire & sel_ext);
      if (fire) begin
        vector <= vec_of(sel_src);
        ext    <= sel_ext;
      end
      if (fire)         ien <= 1'b0;
      else if (ien_set) ien <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
  import irqv_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_HI  = 'h3C,
  parameter logic [ADDR_W-1:0] VEC_MID = 'h34,
  parameter logic [ADDR_W-1:0] VEC_LO  = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              req_edge_i,
  input  logic              req_mid_i,
  input  logic              req_low_i,
  input  logic              req_ext_i,
  input  logic [2:0]        mask_i,
  input  logic              ien_set_i,
  input  logic              pend_clr_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              ext_o,
  output logic              ack_n_o,
  output logic              ien_o
);
  // named internal events, visible to the bound checker
  logic                hi_rise;
  logic                hi_pend;
  logic [DIRECT_N-1:0] direct_live;
  irq_src_e            sel_src;
  logic                fire;
  logic                take_hi;

  assign fire    = boundary_i & ien_o & (sel_src != SRC_NONE);
  assign take_hi = fire & (sel_src == SRC_HI);

  irqv_edge_pend u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_edge_i),
    .clr  (pend_clr_i | take_hi),
    .rise (hi_rise),
    .pend (hi_pend)
  );

  irqv_arbiter u_arb (
    .direct_req ({hi_pend, req_mid_i, req_low_i}),
    .mask       (mask_i),
    .ext_req    (req_ext_i),
    .direct_live(direct_live),
    .sel_src    (sel_src)
  );

  irqv_issue #(
    .ADDR_W (ADDR_W),
    .VEC_HI (VEC_HI),
    .VEC_MID(VEC_MID),
    .VEC_LO (VEC_LO)
  ) u_issue (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .sel_src(sel_src),
    .ien_set(ien_set_i),
    .take   (take_o),
    .vector (vector_o),
    .ext    (ext_o),
    .ack_n  (ack_n_o),
    .ien    (ien_o)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     boundary_i,
  input logic [2:0] mask_i,
  input logic     take_o,
  input logic     ext_o,
  input logic     ack_n_o,
  input logic     ien_o,
  input logic     fire,
  input irq_src_e sel_src,
  input logic     hi_rise,
  input logic     hi_pend
);
  a_r2_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(boundary_i) && $past(ien_o)));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  a_r4_direct_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !ext_o) |-> ack_n_o);
  a_r5_ack_only_on_ext_take: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |-> (take_o && ext_o));
  a_r6_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ien_o);
  a_r7_rise_latches: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rise |=> hi_pend);
  a_r9_mask_blocks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_src == SRC_HI) |-> (hi_pend && !mask_i[2]));
endmodule

bind irq_vector_resolver irqv_checker u_irqv_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .boundary_i(boundary_i),
  .mask_i    (mask_i),
  .take_o    (take_o),
  .ext_o     (ext_o),
  .ack_n_o   (ack_n_o),
  .ien_o     (ien_o),
  .fire      (fire),
  .sel_src   (sel_src),
  .hi_rise   (hi_rise),
  .hi_pend   (hi_pend)
);

// File: tb/irq_vector_resolver_bench.sv
`timescale 1ns/1ps
module irq_vector_resolver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary_i = 0, req_edge_i = 0, req_mid_i = 0, req_low_i = 0, req_ext_i = 0;
  logic [2:0] mask_i = 3'b000;
  logic ien_set_i = 0, pend_clr_i = 0;
  logic take_o, ext_o, ack_n_o, ien_o;
  logic [15:0] vector_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_resolver u_irq_vector_resolver (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_edge_i(req_edge_i),
    .req_mid_i(req_mid_i), .req_low_i(req_low_i), .req_ext_i(req_ext_i),
    .mask_i(mask_i), .ien_set_i(ien_set_i), .pend_clr_i(pend_clr_i),
    .take_o(take_o), .vector_o(vector_o), .ext_o(ext_o), .ack_n_o(ack_n_o), .ien_o(ien_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_take = 0, m_ack_n = 1, m_ien = 0, m_ext = 0, m_pend = 0, m_prev = 0;
  int m_vec = 0;

  function automatic int addr_for(int idx);
    case (idx)
      0: return 'h3C;
      1: return 'h34;
      2: return 'h2C;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_take = 0; m_ack_n = 1; m_ien = 0; m_ext = 0; m_pend = 0; m_prev = 0; m_vec = 0;
    end else begin
      int want[4];
      int winner;
      bit rose;
      want[0] = m_pend && !mask_i[2];
      want[1] = req_mid_i && !mask_i[1];
      want[2] = req_low_i && !mask_i[0];
      want[3] = req_ext_i;
      winner = -1;
      for (int i = 0; i < 4; i++) if (want[i] != 0 && winner < 0) winner = i;
      rose = req_edge_i && (m_prev == 0);
      if (boundary_i && m_ien != 0 && winner >= 0) begin
        m_take = 1;
        m_vec = addr_for(winner);
        m_ext = (winner == 3);
        m_ack_n = (winner == 3) ? 0 : 1;
        m_ien = 0;
        if (winner == 0) m_pend = 0;
      end else begin
        m_take = 0;
        m_ack_n = 1;
        if (ien_set_i) m_ien = 1;
      end
      if (pend_clr_i) m_pend = 0;
      if (rose) m_pend = 1;
      m_prev = req_edge_i;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(take_o == m_take, "R2 model take", take_o, m_take);
      chk(ien_o == m_ien, "R6 model ien", ien_o, m_ien);
      chk(ack_n_o == m_ack_n, "R5 model ack_n", ack_n_o, m_ack_n);
      if (m_take != 0) begin
        chk(vector_o == m_vec, "R4 model vector", vector_o, m_vec);
        chk(ext_o == m_ext, "R5 model ext", ext_o, m_ext);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enable();
    ien_set_i = 1; tick(); ien_set_i = 0;
  endtask

  task automatic pulse_edge();
    req_edge_i = 1; tick(); req_edge_i = 0; tick();
  endtask

  // drive the strobe for one cycle; outputs of that decision are visible on return
  task automatic strobe_expect(input bit exp_take, input int exp_vec, input bit exp_ext, input string tag);
    boundary_i = 1; tick(); boundary_i = 0;
    chk(take_o == exp_take, {tag, " take"}, take_o, exp_take);
    if (exp_take) begin
      chk(vector_o == exp_vec, {tag, " vector"}, vector_o, exp_vec);
      chk(ext_o == exp_ext, {tag, " ext"}, ext_o, exp_ext);
      chk(ack_n_o == !exp_ext, {tag, " ack_n"}, ack_n_o, !exp_ext);
      chk(ien_o == 0, {tag, " R6 ien cleared"}, ien_o, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(take_o == 0, "R1 take at reset", take_o, 0);
    chk(ack_n_o == 1, "R1 ack_n at reset", ack_n_o, 1);
    chk(ien_o == 0, "R1 ien at reset", ien_o, 0);
    rst_n = 1;
    tick();
    chk(take_o == 0 && ack_n_o == 1 && ien_o == 0, "R1 after release", take_o, 0);

    // R2: enable low blocks; R4 mid vector; R6 no second take
    req_mid_i = 1;
    strobe_expect(0, 0, 0, "R2 disabled");
    enable();
    strobe_expect(1, 'h34, 0, "R4 mid");
    strobe_expect(0, 0, 0, "R6 stays disabled");
    req_mid_i = 0;

    // R3 / R7 / R11 / R5: all four at once, drained in order
    pulse_edge();
    req_mid_i = 1; req_low_i = 1; req_ext_i = 1;
    enable();
    strobe_expect(1, 'h3C, 0, "R3 R7 edge first");
    enable();
    strobe_expect(1, 'h34, 0, "R3 R11 mid second");
    req_mid_i = 0;
    enable();
    strobe_expect(1, 'h2C, 0, "R3 low third");
    req_low_i = 0;
    enable();
    strobe_expect(1, 'h0000, 1, "R5 ext last");
    tick();
    chk(ack_n_o == 1, "R5 ack released", ack_n_o, 1);
    req_ext_i = 0;

    // R8: level dropped before the strobe
    enable();
    req_low_i = 1; tick(); req_low_i = 0; tick();
    strobe_expect(0, 0, 0, "R8 dropped level");

    // R9: masks block direct lines, not ext, latched edge survives
    mask_i = 3'b111;
    pulse_edge();
    req_mid_i = 1; req_low_i = 1;
    strobe_expect(0, 0, 0, "R9 all masked");
    req_ext_i = 1;
    strobe_expect(1, 'h0000, 1, "R9 ext unmaskable");
    req_ext_i = 0; req_mid_i = 0; req_low_i = 0; mask_i = 3'b000;
    enable();
    strobe_expect(1, 'h3C, 0, "R9 latched edge kept");

    // R10: software clear discards the edge
    pulse_edge();
    pend_clr_i = 1; tick(); pend_clr_i = 0;
    enable();
    strobe_expect(0, 0, 0, "R10 cleared");

    // R7: held-high edge line does not request twice
    req_edge_i = 1; tick(); tick();
    strobe_expect(1, 'h3C, 0, "R7 held first");
    enable();
    strobe_expect(0, 0, 0, "R7 held no repeat");
    req_edge_i = 0;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule